// File: doc/BRIEF.md
# Floating-Point Register High-Half Move Unit

This unit carries a 32-bit value between a general-purpose register and the upper half of a floating-point register. It holds a 32-entry, 64-bit floating-point register file. Two instructions are decoded from a 32-bit instruction word. Move-from-high returns a sign-extended 64-bit result for the general register file. Move-to-high updates the floating-point register file.

A mode input selects how the floating-point registers are organised:
- **Wide mode:** every register is a full 64 bits, and the upper half is bits 63:32 of the named register.
- **Paired mode:** each register holds a 32-bit value, and an even register's high half lives in the next odd register.

In paired mode, naming an odd register does not raise a fault. The unit returns or stores a fixed marker constant instead, and raises a one-cycle warning. Every move is gated by an FPU-enabled input. When that input is low, the unit reports the FPU as unusable and does nothing else.

All results are registered. The register file updates on the same clock edge, so the instruction presented in the next cycle already sees the new contents.

Top module: `fpr_hi_move`

## Requirements
- R1: An instruction is recognised only when all of the following hold:
  - bits 31:26 are 010001;
  - bits 25:21 are 00011 (move-from-high) or 00111 (move-to-high);
  - bits 10:0 are all zero.

  The destination general register number is bits 20:16 and the floating-point register number is bits 15:11. Any other word changes no register and raises no output.
- R2: For an enabled move-from-high, `gpr_we_o` is high in the cycle after the instruction is presented, with `gpr_idx_o` equal to bits 20:16. A register written by a move-to-high is visible to an instruction presented in the very next cycle.
- R3: In wide mode (`wide_mode_i`=1), move-from-high returns bits 63:32 of the named register, sign-extended to 64 bits.
- R4: In wide mode, move-to-high puts `gpr_i[31:0]` into bits 63:32 of the named register and leaves its bits 31:0 unchanged. It produces no general-register write.
- R5: In paired mode (`wide_mode_i`=0) with an even register number n, move-from-high returns bits 31:0 of register n+1, sign-extended.
- R6: In paired mode with an even n, move-to-high stores `gpr_i[31:0]` zero-extended into register n+1.
- R7: In paired mode with an odd n, move-from-high returns 0x000000000BADF00D.
- R8: In paired mode with an odd n, move-to-high stores 0x00000000DEADC0DE into register n itself and produces no general-register write.
- R9: A recognised instruction with `fpu_en_i`=0 raises `fpu_unusable_o` for the next cycle. It produces no general-register write, no register-file update and no warning.
- R10: `warn_o` is high for exactly the one cycle after each enabled paired-mode move that names an odd register, and is low otherwise.
- R11: Reset clears every floating-point register to zero and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word |
| gpr_i | input | 64 | General register source value |
| fpu_en_i | input | 1 | FPU usable |
| wide_mode_i | input | 1 | 1 = 64-bit registers, 0 = paired 32-bit registers |
| gpr_o | output | 64 | General register result (zero when not writing) |
| gpr_we_o | output | 1 | General register write enable |
| gpr_idx_o | output | 5 | Destination general register number |
| fpu_unusable_o | output | 1 | FPU-unusable flag |
| warn_o | output | 1 | Odd-register misuse warning |

## Verification
The bench targets the corner cases below, each paired with the failure it would expose:
- **Wide-mode move-to-high.** A write to a register's upper half is followed by a paired-mode read of the same register's lower word. A design that rewrote the whole entry would return the new data or zero instead of the preserved word.
- **Pairing direction.** Paired-mode writes go to the even register and are read back through the odd one. This catches a design that skipped the pairing or the zero-extension.
- **Odd-register path.** The odd-register read and write are followed by reads of the marker value. This catches a design that faulted, wrote the wrong register or forgot the warning.
- **Disabled FPU and malformed words.** Each is followed by a read of the register it targeted. A design that still updated that register shows the change.

// File: rtl/fhm_pkg.sv
package fhm_pkg;
  localparam int unsigned FPR_W   = 64;
  localparam int unsigned HALF_W  = FPR_W / 2;
  localparam int unsigned NUM_FPR = 32;
  localparam int unsigned IDX_W   = $clog2(NUM_FPR);

  localparam logic [5:0]  OPC_FPU   = 6'b010001;
  localparam logic [4:0]  SUB_MFH   = 5'b00011;
  localparam logic [4:0]  SUB_MTH   = 5'b00111;
  localparam logic [31:0] MARK_RD   = 32'h0BAD_F00D;
  localparam logic [31:0] MARK_WR   = 32'hDEAD_C0DE;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MFH  = 2'd1,
    OP_MTH  = 2'd2
  } hmove_op_e;
endpackage

// File: rtl/fhm_decode.sv
module fhm_decode
  import fhm_pkg::*;
(
  input  logic [31:0]      instr_i,
  output hmove_op_e        op_o,
  output logic [IDX_W-1:0] rt_o,
  output logic [IDX_W-1:0] fs_o
);
  logic base_ok;

  assign base_ok = (instr_i[31:26] == OPC_FPU) && (instr_i[10:0] == 11'd0);
  assign rt_o    = instr_i[20:16];
  assign fs_o    = instr_i[15:11];

  always_comb begin
    op_o = OP_NONE;
    if (base_ok) begin
      if (instr_i[25:21] == SUB_MFH)      op_o = OP_MFH;
      else if (instr_i[25:21] == SUB_MTH) op_o = OP_MTH;
    end
  end
endmodule

// File: rtl/fhm_regfile.sv
module fhm_regfile #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))    mem_q[g] <= wdata_i;
    end
  end

  // read returns the pre-edge value
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fhm_exec.sv
module fhm_exec
  import fhm_pkg::*;
(
  input  hmove_op_e        op_i,
  input  logic             fpu_en_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] rt_i,
  input  logic [IDX_W-1:0] fs_i,
  input  logic [FPR_W-1:0] gpr_i,
  input  logic [FPR_W-1:0] rdata_i,
  output logic [IDX_W-1:0] raddr_o,
  output logic             fwe_o,
  output logic [IDX_W-1:0] fwaddr_o,
  output logic [FPR_W-1:0] fwdata_o,
  output logic             res_we_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [FPR_W-1:0] res_data_o,
  output logic             unus_o,
  output logic             warn_o
);
  logic             odd_fs;
  logic [IDX_W-1:0] pair_idx;

  assign odd_fs   = fs_i[0];
  assign pair_idx = {fs_i[IDX_W-1:1], 1'b1};
  assign raddr_o  = wide_i ? fs_i : pair_idx;

  function automatic logic [FPR_W-1:0] sext(input logic [HALF_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v};
  endfunction

  always_comb begin
    fwe_o      = 1'b0;
    fwaddr_o   = fs_i;
    fwdata_o   = '0;
    res_we_o   = 1'b0;
    res_idx_o  = '0;
    res_data_o = '0;
    unus_o     = 1'b0;
    warn_o     = 1'b0;
    if (op_i != OP_NONE) begin
      if (!fpu_en_i) begin
        unus_o = 1'b1;
      end else begin
        warn_o = !wide_i && odd_fs;
        if (op_i == OP_MFH) begin
          res_we_o  = 1'b1;
          res_idx_o = rt_i;
          if (wide_i)       res_data_o = sext(rdata_i[FPR_W-1:HALF_W]);
          else if (!odd_fs) res_data_o = sext(rdata_i[HALF_W-1:0]);
          else              res_data_o = {{HALF_W{1'b0}}, MARK_RD};
        end else begin
          fwe_o = 1'b1;
          if (wide_i) begin
            fwaddr_o = fs_i;
            fwdata_o = {gpr_i[HALF_W-1:0], rdata_i[HALF_W-1:0]};
          end else if (!odd_fs) begin
            fwaddr_o = pair_idx;
            fwdata_o = {{HALF_W{1'b0}}, gpr_i[HALF_W-1:0]};
          end else begin
            fwaddr_o = fs_i;
            fwdata_o = {{HALF_W{1'b0}}, MARK_WR};
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpr_hi_move.sv
module fpr_hi_move
  import fhm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       instr_i,
  input  logic [FPR_W-1:0]  gpr_i,
  input  logic              fpu_en_i,
  input  logic              wide_mode_i,
  output logic [FPR_W-1:0]  gpr_o,
  output logic              gpr_we_o,
  output logic [IDX_W-1:0]  gpr_idx_o,
  output logic              fpu_unusable_o,
  output logic              warn_o
);
  hmove_op_e        op;
  logic [IDX_W-1:0] rt, fs, raddr, fwaddr, res_idx;
  logic [FPR_W-1:0] rdata, fwdata, res_data;
  logic             fwe, res_we, unus, warn;

  fhm_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op),
    .rt_o    (rt),
    .fs_o    (fs)
  );

  fhm_regfile #(.DEPTH(NUM_FPR), .WIDTH(FPR_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (fwe),
    .waddr_i (fwaddr),
    .wdata_i (fwdata)
  );

  fhm_exec u_exec (
    .op_i       (op),
    .fpu_en_i   (fpu_en_i),
    .wide_i     (wide_mode_i),
    .rt_i       (rt),
    .fs_i       (fs),
    .gpr_i      (gpr_i),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .fwe_o      (fwe),
    .fwaddr_o   (fwaddr),
    .fwdata_o   (fwdata),
    .res_we_o   (res_we),
    .res_idx_o  (res_idx),
    .res_data_o (res_data),
    .unus_o     (unus),
    .warn_o     (warn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpr_o          <= '0;
      gpr_we_o       <= 1'b0;
      gpr_idx_o      <= '0;
      fpu_unusable_o <= 1'b0;
      warn_o         <= 1'b0;
    end else begin
      gpr_o          <= res_data;
      gpr_we_o       <= res_we;
      gpr_idx_o      <= res_idx;
      fpu_unusable_o <= unus;
      warn_o         <= warn;
    end
  end
endmodule

// File: rtl/fpr_hi_move_chk.sv
module fpr_hi_move_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic        fpu_en_i,
  input logic        wide_mode_i,
  input logic [63:0] gpr_o,
  input logic        gpr_we_o,
  input logic [4:0]  gpr_idx_o,
  input logic        fpu_unusable_o,
  input logic        warn_o
);
  logic is_cop, is_mf, is_mt, odd_pair;

  assign is_cop   = (instr_i[31:26] == 6'b010001) && (instr_i[10:0] == 11'd0);
  assign is_mf    = is_cop && (instr_i[25:21] == 5'b00011);
  assign is_mt    = is_cop && (instr_i[25:21] == 5'b00111);
  assign odd_pair = (is_mf || is_mt) && fpu_en_i && !wide_mode_i && instr_i[11];

  AST_IGNORED_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_mf || is_mt) |=> !gpr_we_o && !fpu_unusable_o && !warn_o); // R1
  AST_MF_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mf && fpu_en_i |=> gpr_we_o && (gpr_idx_o == $past(instr_i[20:16]))); // R2
  AST_WIDE_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mf && fpu_en_i && wide_mode_i |=> gpr_o[63:32] == {32{gpr_o[31]}}); // R3
  AST_MT_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mt |=> !gpr_we_o); // R4
  AST_ODD_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mf && odd_pair |=> gpr_o == 64'h0000_0000_0BAD_F00D); // R7
  AST_UNUSABLE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mf || is_mt) && !fpu_en_i |=> fpu_unusable_o && !gpr_we_o && !warn_o); // R9
  AST_WARN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odd_pair |=> !warn_o); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gpr_we_o, fpu_unusable_o})); // R9
endmodule

bind fpr_hi_move fpr_hi_move_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_i        (instr_i),
  .fpu_en_i       (fpu_en_i),
  .wide_mode_i    (wide_mode_i),
  .gpr_o          (gpr_o),
  .gpr_we_o       (gpr_we_o),
  .gpr_idx_o      (gpr_idx_o),
  .fpu_unusable_o (fpu_unusable_o),
  .warn_o         (warn_o)
);

// File: tb/fpr_hi_move_bench.sv
module fpr_hi_move_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wide;
    logic        en;
    logic [31:0] instr;
    logic [63:0] gpr;
    logic        we;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        unus;
    logic        warn;
  } vec_t;

  localparam logic [5:0] OPC = 6'b010001;
  localparam logic [4:0] MF  = 5'b00011;
  localparam logic [4:0] MT  = 5'b00111;
  localparam int NV = 23;

  localparam vec_t VECS [NV] = '{
    // 0 R11: paired read of reg1 after reset
    '{1'b0,1'b1,{OPC,MF,5'd1,5'd0,11'd0},64'h0,1'b1,5'd1,64'h0,1'b0,1'b0},
    // 1 R4: wide write reg4 high
    '{1'b1,1'b1,{OPC,MT,5'd0,5'd4,11'd0},64'h1111_1111_8000_0001,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 2 R3 R2: back-to-back read, negative
    '{1'b1,1'b1,{OPC,MF,5'd2,5'd4,11'd0},64'h0,1'b1,5'd2,64'hFFFF_FFFF_8000_0001,1'b0,1'b0},
    // 3 R6: paired write to reg3 via fs=2
    '{1'b0,1'b1,{OPC,MT,5'd0,5'd2,11'd0},64'h5555_5555_1234_5678,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 4 R4: wide write reg3 high
    '{1'b1,1'b1,{OPC,MT,5'd0,5'd3,11'd0},64'h9ABC_DEF0_7EAD_BEEF,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 5 R3: positive high half
    '{1'b1,1'b1,{OPC,MF,5'd3,5'd3,11'd0},64'h0,1'b1,5'd3,64'h0000_0000_7EAD_BEEF,1'b0,1'b0},
    // 6 R4: low half of reg3 kept
    '{1'b0,1'b1,{OPC,MF,5'd4,5'd2,11'd0},64'h0,1'b1,5'd4,64'h0000_0000_1234_5678,1'b0,1'b0},
    // 7 R6: paired write reg7
    '{1'b0,1'b1,{OPC,MT,5'd0,5'd6,11'd0},64'h0000_0000_CAFE_F00D,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 8 R5: paired read sign-extends
    '{1'b0,1'b1,{OPC,MF,5'd5,5'd6,11'd0},64'h0,1'b1,5'd5,64'hFFFF_FFFF_CAFE_F00D,1'b0,1'b0},
    // 9 R6: upper half of paired write is zero
    '{1'b1,1'b1,{OPC,MF,5'd6,5'd7,11'd0},64'h0,1'b1,5'd6,64'h0,1'b0,1'b0},
    // 10 R7 R10: odd read marker
    '{1'b0,1'b1,{OPC,MF,5'd7,5'd5,11'd0},64'h0,1'b1,5'd7,64'h0000_0000_0BAD_F00D,1'b0,1'b1},
    // 11 R8 R10: odd write marker
    '{1'b0,1'b1,{OPC,MT,5'd0,5'd9,11'd0},64'h1234_5678_1234_5678,1'b0,5'd0,64'h0,1'b0,1'b1},
    // 12 R8 R10: marker landed in reg9, warn gone
    '{1'b0,1'b1,{OPC,MF,5'd8,5'd8,11'd0},64'h0,1'b1,5'd8,64'hFFFF_FFFF_DEAD_C0DE,1'b0,1'b0},
    // 13 R8: marker upper half zero
    '{1'b1,1'b1,{OPC,MF,5'd9,5'd9,11'd0},64'h0,1'b1,5'd9,64'h0,1'b0,1'b0},
    // 14 R9: disabled write
    '{1'b1,1'b0,{OPC,MT,5'd0,5'd4,11'd0},64'h0,1'b0,5'd0,64'h0,1'b1,1'b0},
    // 15 R9: reg4 untouched
    '{1'b1,1'b1,{OPC,MF,5'd10,5'd4,11'd0},64'h0,1'b1,5'd10,64'hFFFF_FFFF_8000_0001,1'b0,1'b0},
    // 16 R9: disabled read
    '{1'b1,1'b0,{OPC,MF,5'd11,5'd4,11'd0},64'h0,1'b0,5'd0,64'h0,1'b1,1'b0},
    // 17 R1: low bits nonzero
    '{1'b1,1'b1,{OPC,MT,5'd0,5'd4,11'd1},64'h0,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 18 R1: reg4 untouched
    '{1'b1,1'b1,{OPC,MF,5'd31,5'd4,11'd0},64'h0,1'b1,5'd31,64'hFFFF_FFFF_8000_0001,1'b0,1'b0},
    // 19 R1: wrong opcode, disabled: no flag
    '{1'b1,1'b0,{6'b010010,MT,5'd0,5'd4,11'd0},64'h0,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 20 R1: unknown sub-op
    '{1'b1,1'b1,{OPC,5'b00100,5'd1,5'd4,11'd0},64'h0,1'b0,5'd0,64'h0,1'b0,1'b0},
    // 21 R10: odd register in wide mode, no warn
    '{1'b1,1'b1,{OPC,MF,5'd12,5'd5,11'd0},64'h0,1'b1,5'd12,64'h0,1'b0,1'b0},
    // 22 R9 R10: paired odd disabled, no warn
    '{1'b0,1'b0,{OPC,MT,5'd0,5'd9,11'd0},64'h0,1'b0,5'd0,64'h0,1'b1,1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] gpr_i = '0;
  logic        fpu_en_i = 1'b0;
  logic        wide_mode_i = 1'b0;
  logic [63:0] gpr_o;
  logic        gpr_we_o;
  logic [4:0]  gpr_idx_o;
  logic        fpu_unusable_o;
  logic        warn_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpr_hi_move u_fpr_hi_move (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .instr_i        (instr_i),
    .gpr_i          (gpr_i),
    .fpu_en_i       (fpu_en_i),
    .wide_mode_i    (wide_mode_i),
    .gpr_o          (gpr_o),
    .gpr_we_o       (gpr_we_o),
    .gpr_idx_o      (gpr_idx_o),
    .fpu_unusable_o (fpu_unusable_o),
    .warn_o         (warn_o)
  );

  task automatic check_out(input string tag, input logic we, input logic [4:0] idx,
                           input logic [63:0] data, input logic unus, input logic warn);
    checks++;
    if (gpr_we_o !== we || gpr_idx_o !== idx || gpr_o !== data ||
        fpu_unusable_o !== unus || warn_o !== warn) begin
      errors++;
      $display("FAIL %s: got we=%b idx=%0d data=%h unus=%b warn=%b exp we=%b idx=%0d data=%h unus=%b warn=%b",
               tag, gpr_we_o, gpr_idx_o, gpr_o, fpu_unusable_o, warn_o,
               we, idx, data, unus, warn);
    end
  endtask

  task automatic step(input logic wide, input logic en, input logic [31:0] ins,
                      input logic [63:0] g);
    wide_mode_i = wide;
    fpu_en_i    = en;
    instr_i     = ins;
    gpr_i       = g;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check_out("R11 reset outputs", 1'b0, 5'd0, 64'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wide, VECS[i].en, VECS[i].instr, VECS[i].gpr);
      check_out($sformatf("vector %0d", i), VECS[i].we, VECS[i].idx, VECS[i].data,
                VECS[i].unus, VECS[i].warn);
    end
    // R10: warning pulse lasts one cycle while an idle word follows
    step(1'b0, 1'b1, {OPC, MF, 5'd1, 5'd3, 11'd0}, 64'h0);
    check_out("R10 pulse on", 1'b1, 5'd1, 64'h0000_0000_0BAD_F00D, 1'b0, 1'b1);
    step(1'b0, 1'b1, 32'h0, 64'h0);
    check_out("R10 pulse off", 1'b0, 5'd0, 64'h0, 1'b0, 1'b0);
    // R11: mid-run reset clears the register file
    step(1'b1, 1'b1, {OPC, MF, 5'd2, 5'd4, 11'd0}, 64'h0);
    rst_ni = 1'b0;
    #1;
    check_out("R11 async reset outputs", 1'b0, 5'd0, 64'h0, 1'b0, 1'b0);
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    step(1'b1, 1'b1, {OPC, MF, 5'd2, 5'd4, 11'd0}, 64'h0);
    check_out("R11 reg4 cleared", 1'b1, 5'd2, 64'h0, 1'b0, 1'b0);
    step(1'b0, 1'b1, {OPC, MF, 5'd3, 5'd8, 11'd0}, 64'h0);
    check_out("R11 reg9 cleared", 1'b1, 5'd3, 64'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule